// File: doc/BRIEF.md
# Processor Debug-Mode Sequencer

This block sequences a processor core between normal execution and a halted debug mode in which an external debugger drives the core. It holds the mode in a two-state machine. While the core is halted, every instruction fetch is redirected to the debugger's port whatever its address. Loads and stores keep going to ordinary memory. The core's freeze indication is raised for the whole halt.

Faults that arise during the halt are not handled as traps. Each such fault sets a bit in a sticky cause register and raises a single-cycle report toward the debugger. Execution stays halted. When the halt begins, the block asks the datapath to capture the program counter and status word into the two save/restore registers, and to clear the external-interrupt-enable bit. Nothing writes those two registers again until the next entry. A return-from-interrupt strobe ends the halt.

States and transitions: `ST_NORMAL` (running) and `ST_DEBUG` (halted). Transition *enter* goes from `ST_NORMAL` to `ST_DEBUG` on a debug request or on a breakpoint or watchpoint line. Transition *resume* goes from `ST_DEBUG` to `ST_NORMAL` on the return strobe. Every other cycle is a *hold* in the current state.

Top module: `dbgmode_ctrl`

## Requirements
- R1: In `ST_DEBUG` a fetch request drives `fetch_dev` and never `fetch_mem`, except in a report cycle (see R4). In `ST_NORMAL` a fetch request drives `fetch_mem`. `mem_ls_en` follows `ls_req` in both states.
- R2: In `ST_DEBUG`, a recognised cause line sets its own bit of `cause_rdata` at the next edge, ORed with the bits already held, and the state stays `ST_DEBUG`. Cause bit map: 0 external interrupt, 1 decrementer, 2 breakpoint, 3 watchpoint, 4 and up general faults.
- R3: A cycle with at least one recognised cause raises `exc_report` in exactly the following cycle. A single isolated cause gives a pulse one cycle long.
- R4: While `exc_report` is high, a pending fetch is held back: `fetch_stall` is high and `fetch_dev` is low. The report therefore precedes the next fetch.
- R5: `srr0_we` and `srr1_we` are high only in the cycle of the *enter* transition, carrying `pc_in` and `msr_in` on `srr0_wdata` and `srr1_wdata`. A fault recognised in `ST_DEBUG` never raises them.
- R6: Breakpoint (bit 2) and watchpoint (bit 3) lines are never recognised in `ST_DEBUG`, whatever the status word holds. They are never recorded and raise no report. In `ST_NORMAL`, either line causes *enter*.
- R7: `ee_clr` pulses in the *enter* cycle. In `ST_DEBUG`, the external (bit 0) and decrementer (bit 1) lines are recognised only while `msr_in[EE_BIT]` (bit 15 by default) is 1.
- R8: An external line held high with `msr_in[EE_BIT]` set is recognised again in every `ST_DEBUG` cycle, so `exc_report` stays high in every following cycle.
- R9: `rfi_strobe` in `ST_DEBUG` causes *resume* at the next edge and `freeze` falls. In `ST_NORMAL`, `rfi_strobe` has no effect.
- R10: A `cause_rd` strobe clears `cause_rdata` at the next edge. A bit recognised in the same cycle as the read survives the clear.
- R11: `freeze` is high from the edge that takes *enter* until the edge that takes *resume*.
- R12: Under reset the block is in `ST_NORMAL` with `freeze` low, `exc_report` low and `cause_rdata` zero.
- R13: `dbg_req` in `ST_DEBUG` is ignored: no save-register write and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_req | input | 1 | Request to halt into debug mode |
| exc_lines | input | NEXC | Exception cause lines, bit map as in R2 |
| rfi_strobe | input | 1 | Return-from-interrupt executed |
| fetch_req | input | 1 | Instruction fetch request |
| ls_req | input | 1 | Load/store request |
| pc_in | input | XLEN | Current program counter |
| msr_in | input | XLEN | Current status word |
| cause_rd | input | 1 | Special-register read of the cause register |
| freeze | output | 1 | Core halted in debug mode |
| fetch_dev | output | 1 | Issue fetch to the debugger port |
| fetch_mem | output | 1 | Issue fetch to memory |
| fetch_stall | output | 1 | Fetch held back behind a report |
| mem_ls_en | output | 1 | Load/store issued to memory |
| srr0_we | output | 1 | Write enable for save register 0 |
| srr1_we | output | 1 | Write enable for save register 1 |
| srr0_wdata | output | XLEN | Value for save register 0 |
| srr1_wdata | output | XLEN | Value for save register 1 |
| ee_clr | output | 1 | Clear the external-interrupt-enable bit |
| exc_report | output | 1 | One-cycle fault report to the debugger |
| cause_rdata | output | NEXC | Cause register read data |

## Verification
Two functions can meet in a single cycle. A cause register read can coincide with a new recognised fault, and the return strobe can coincide with a fault. The bench forces both collisions directly: a read together with a general fault, and a return together with a fault. It then judges the result against R10 and R2/R3: only the new bit may survive the read, and the report must still appear in the cycle after the resume, even though the core is by then running. A long run of random stimulus compares every output with a behavioural model on every clock. That run also produces entries coinciding with breakpoints, and reads coinciding with external interrupts held at level.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
    typedef enum logic [0:0] {
        ST_NORMAL = 1'b0,
        ST_DEBUG  = 1'b1
    } dbg_state_e;

    localparam int EXC_EXT  = 0;
    localparam int EXC_DEC  = 1;
    localparam int EXC_BKPT = 2;
    localparam int EXC_WPT  = 3;
endpackage

// File: rtl/dbgm_fsm.sv
module dbgm_fsm
    import dbgm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dbg_req,
    input  logic       bkpt_hit,
    input  logic       wpt_hit,
    input  logic       rfi_strobe,
    output dbg_state_e state,
    output logic       enter
);
    dbg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // next state and transition outputs
    always_comb begin
        state_d = state_q;
        enter   = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                if (dbg_req || bkpt_hit || wpt_hit) begin
                    enter   = 1'b1;
                    state_d = ST_DEBUG;
                end
            end
            ST_DEBUG: begin
                if (rfi_strobe) state_d = ST_NORMAL;
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/dbgm_exc_filter.sv
module dbgm_exc_filter
    import dbgm_pkg::*;
#(
    parameter int NEXC = 8
) (
    input  logic            in_debug,
    input  logic            ee_en,
    input  logic [NEXC-1:0] exc_lines,
    output logic [NEXC-1:0] recognised
);
    logic [NEXC-1:0] allow;

    for (genvar i = 0; i < NEXC; i++) begin : g_allow
        if (i == EXC_BKPT || i == EXC_WPT) begin : g_never
            assign allow[i] = 1'b0;
        end else if (i == EXC_EXT || i == EXC_DEC) begin : g_masked
            assign allow[i] = ee_en;
        end else begin : g_always
            assign allow[i] = 1'b1;
        end
    end

    assign recognised = exc_lines & allow & {NEXC{in_debug}};
endmodule

// File: rtl/dbgm_cause_reg.sv
module dbgm_cause_reg #(
    parameter int NEXC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXC-1:0] recognised,
    input  logic            rd_clear,
    output logic [NEXC-1:0] cause_q,
    output logic            report_q
);
    logic [NEXC-1:0] kept;

    assign kept = rd_clear ? '0 : cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q  <= '0;
            report_q <= 1'b0;
        end else begin
            cause_q  <= kept | recognised;
            report_q <= |recognised;
        end
    end
endmodule

// File: rtl/dbgmode_ctrl.sv
module dbgmode_ctrl
    import dbgm_pkg::*;
#(
    parameter int NEXC   = 8,
    parameter int XLEN   = 32,
    parameter int EE_BIT = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_req,
    input  logic [NEXC-1:0] exc_lines,
    input  logic            rfi_strobe,
    input  logic            fetch_req,
    input  logic            ls_req,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] msr_in,
    input  logic            cause_rd,
    output logic            freeze,
    output logic            fetch_dev,
    output logic            fetch_mem,
    output logic            fetch_stall,
    output logic            mem_ls_en,
    output logic            srr0_we,
    output logic            srr1_we,
    output logic [XLEN-1:0] srr0_wdata,
    output logic [XLEN-1:0] srr1_wdata,
    output logic            ee_clr,
    output logic            exc_report,
    output logic [NEXC-1:0] cause_rdata
);
    dbg_state_e      state;
    logic            enter;
    logic [NEXC-1:0] recognised;
    logic            report_q;

    dbgm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_req    (dbg_req),
        .bkpt_hit   (exc_lines[EXC_BKPT]),
        .wpt_hit    (exc_lines[EXC_WPT]),
        .rfi_strobe (rfi_strobe),
        .state      (state),
        .enter      (enter)
    );

    dbgm_exc_filter #(.NEXC(NEXC)) u_filter (
        .in_debug   (state == ST_DEBUG),
        .ee_en      (msr_in[EE_BIT]),
        .exc_lines  (exc_lines),
        .recognised (recognised)
    );

    dbgm_cause_reg #(.NEXC(NEXC)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .recognised (recognised),
        .rd_clear   (cause_rd),
        .cause_q    (cause_rdata),
        .report_q   (report_q)
    );

    // output process driven by the state
    always_comb begin
        freeze      = 1'b0;
        fetch_dev   = 1'b0;
        fetch_mem   = 1'b0;
        fetch_stall = 1'b0;
        unique case (state)
            ST_NORMAL: fetch_mem = fetch_req;
            ST_DEBUG: begin
                freeze      = 1'b1;
                fetch_dev   = fetch_req && !report_q;
                fetch_stall = fetch_req && report_q;
            end
            default: ;
        endcase
    end

    assign mem_ls_en  = ls_req;
    assign srr0_we    = enter;
    assign srr1_we    = enter;
    assign ee_clr     = enter;
    assign srr0_wdata = pc_in;
    assign srr1_wdata = msr_in;
    assign exc_report = report_q;
endmodule

// File: rtl/dbgmode_ctrl_chk.sv
module dbgmode_ctrl_chk
    import dbgm_pkg::*;
#(
    parameter int NEXC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_req,
    input logic            rfi_strobe,
    input logic            cause_rd,
    input logic            freeze,
    input logic            fetch_dev,
    input logic            exc_report,
    input logic            srr0_we,
    input logic            ee_clr,
    input logic [NEXC-1:0] cause_rdata
);
    p_fetch_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && fetch_req && !exc_report |-> fetch_dev);

    p_report_needs_debug_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze && !$past(freeze) |-> !exc_report);

    p_report_before_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_report |-> !fetch_dev);

    p_srr_only_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srr0_we |-> !freeze);

    p_entry_freezes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srr0_we |=> freeze);

    p_ee_clear_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ee_clr |=> freeze);

    p_no_bkpt_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_rdata[EXC_BKPT] && !cause_rdata[EXC_WPT]);

    p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && rfi_strobe |=> !freeze);

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cause_rd && !freeze |=> cause_rdata == '0);
endmodule

bind dbgmode_ctrl dbgmode_ctrl_chk #(.NEXC(NEXC)) u_chk (.*);

// File: tb/tb_dbgmode_ctrl.sv
module tb_dbgmode_ctrl;
    localparam int NEXC = 8;
    localparam int XLEN = 32;
    localparam logic [31:0] EE = 32'h0000_8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbg_req = 0, rfi_strobe = 0, fetch_req = 0, ls_req = 0, cause_rd = 0;
    logic [NEXC-1:0] exc_lines = '0;
    logic [XLEN-1:0] pc_in = '0, msr_in = '0;
    logic freeze, fetch_dev, fetch_mem, fetch_stall, mem_ls_en;
    logic srr0_we, srr1_we, ee_clr, exc_report;
    logic [XLEN-1:0] srr0_wdata, srr1_wdata;
    logic [NEXC-1:0] cause_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    bit m_dbg = 0;
    bit m_rep = 0;
    logic [NEXC-1:0] m_cause = '0;

    always #4 clk = ~clk;

    dbgmode_ctrl dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic req, input logic [7:0] exc, input logic rfi,
                        input logic fr, input logic ls, input logic rd,
                        input logic [31:0] pc, input logic [31:0] msr);
        bit enter;
        logic [NEXC-1:0] rec;
        dbg_req = req; exc_lines = exc; rfi_strobe = rfi; fetch_req = fr;
        ls_req = ls; cause_rd = rd; pc_in = pc; msr_in = msr;
        #1;
        enter = !m_dbg && (req || exc[2] || exc[3]);
        rec = '0;
        if (m_dbg) begin
            for (int i = 0; i < NEXC; i++) begin
                if (i == 2 || i == 3) rec[i] = 1'b0;
                else if (i < 2) rec[i] = exc[i] && msr[15];
                else rec[i] = exc[i];
            end
        end
        check("R11 freeze", 32'(freeze), 32'(m_dbg));
        check("R1 fetch_dev", 32'(fetch_dev), 32'(m_dbg && fr && !m_rep));
        check("R1 fetch_mem", 32'(fetch_mem), 32'(!m_dbg && fr));
        check("R4 fetch_stall", 32'(fetch_stall), 32'(m_dbg && fr && m_rep));
        check("R1 mem_ls_en", 32'(mem_ls_en), 32'(ls));
        check("R5 srr0_we", 32'(srr0_we), 32'(enter));
        check("R5 srr1_we", 32'(srr1_we), 32'(enter));
        check("R5 srr0_wdata", srr0_wdata, pc);
        check("R5 srr1_wdata", srr1_wdata, msr);
        check("R7 ee_clr", 32'(ee_clr), 32'(enter));
        check("R3 exc_report", 32'(exc_report), 32'(m_rep));
        check("R2 cause_rdata", 32'(cause_rdata), 32'(m_cause));
        m_cause = (rd ? '0 : m_cause) | rec;
        m_rep = |rec;
        if (enter) m_dbg = 1;
        else if (m_dbg && rfi) m_dbg = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset freeze", 32'(freeze), 0);
        check("R12 reset report", 32'(exc_report), 0);
        check("R12 reset cause", 32'(cause_rdata), 0);
        check("R12 reset fetch_mem", 32'(fetch_mem), 0);
        rst_n = 1'b1;
        step(0, 8'h00, 0, 1, 0, 0, 32'h40, EE);
        step(1, 8'h00, 0, 1, 1, 0, 32'h100, EE);        // enter
        check("R11 freeze after enter", 32'(freeze), 1);
        check("R13 dbg_req ignored in debug", 32'(srr0_we), 0);
        step(1, 8'h00, 0, 1, 1, 0, 32'h104, EE);
        check("R13 still halted", 32'(freeze), 1);
        step(0, 8'h10, 0, 1, 0, 0, 32'h108, EE);        // general fault
        check("R3 report one cycle later", 32'(exc_report), 1);
        check("R4 fetch held behind report", 32'(fetch_stall), 1);
        check("R2 fault bit recorded", 32'(cause_rdata), 32'h10);
        check("R2 stays in debug", 32'(freeze), 1);
        step(0, 8'h00, 0, 1, 0, 0, 32'h10c, EE);
        check("R3 pulse lasts one cycle", 32'(exc_report), 0);
        step(0, 8'h03, 0, 1, 0, 0, 32'h110, 32'h0);     // ext+dec with EE clear
        check("R7 masked external not recognised", 32'(exc_report), 0);
        check("R7 masked external not recorded", 32'(cause_rdata), 32'h10);
        for (int k = 0; k < 3; k++) begin
            step(0, 8'h01, 0, 1, 0, 0, 32'h114, EE);    // level external, EE set
            check("R8 level external re-reported", 32'(exc_report), 1);
        end
        step(0, 8'h0c, 0, 1, 0, 0, 32'h118, 32'hffff_ffff); // bkpt+wpt
        check("R6 breakpoint gives no report", 32'(exc_report), 0);
        check("R6 breakpoint not recorded", 32'(cause_rdata), 32'h11);
        check("R6 breakpoint keeps debug", 32'(freeze), 1);
        step(0, 8'h20, 0, 0, 0, 1, 32'h11c, EE);        // read + new fault
        check("R10 new bit survives read", 32'(cause_rdata), 32'h20);
        step(0, 8'h00, 0, 0, 0, 1, 32'h120, EE);
        check("R10 read clears", 32'(cause_rdata), 0);
        step(0, 8'h00, 1, 1, 0, 0, 32'h124, EE);        // resume
        check("R9 resume drops freeze", 32'(freeze), 0);
        check("R1 fetch back to memory", 32'(fetch_mem), 1);
        step(0, 8'h00, 1, 1, 0, 0, 32'h128, EE);
        check("R9 return in normal ignored", 32'(freeze), 0);
        step(0, 8'h04, 0, 0, 0, 0, 32'h200, EE);        // breakpoint enters
        check("R6 breakpoint enters debug", 32'(freeze), 1);
        step(0, 8'h40, 1, 0, 0, 0, 32'h204, EE);        // fault with resume
        check("R9 resume with fault", 32'(freeze), 0);
        check("R3 report after resume", 32'(exc_report), 1);
        check("R2 bit kept across resume", 32'(cause_rdata), 32'h40);
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) == 0,
                 8'($urandom) & 8'($urandom) & 8'($urandom),
                 ($urandom % 6) == 0, 1'($urandom), 1'($urandom),
                 ($urandom % 5) == 0, $urandom, $urandom);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule